// File: doc/BRIEF.md
# Multi-mode 16-bit measurement timer

This block is one 16-bit timer channel with three ways of working. As an interval timer it counts down on an internally prescaled tick. It reloads from a programmed value when it passes zero and emits a one-cycle underflow pulse, which a neighbouring channel can take as its cascade input. As an event counter it counts down in the same way, but each step comes from an edge on an external pin or from a pulse on the cascade input. As a measurement unit it counts prescaled ticks upward and captures the count whenever the external signal produces a measurement event. A measurement event is one edge of a chosen direction when measuring the period, or either edge when measuring the width.

Software programs the block through a small write port that has two targets, a reload word and a control byte, and it runs the block with a level `start` input. The external pin passes through a two-stage synchroniser before edges are detected. A single interrupt line pulses for one cycle on underflow, on each capture, and on counter overflow during measurement. An overflow also sets a sticky flag that the next control write clears.

Top module: `mtmr_top`

## Requirements
- R1: After reset `rd_val`, `irq`, `uf_out` and `ovf_flag` are 0, the mode is interval timer and the reload word is 0.
- R2: In interval mode (control bits [1:0] = 0) the counter decrements once per selected tick. When a tick finds it at 0 it reloads, keeps running and pulses `uf_out` for one cycle, so underflows recur every (reload+1) ticks.
- R3: Control bits [7:5] select the tick source: 0 every cycle, 1 every 8th cycle, 2 every 32nd, 3 every 64th, 4 every 32nd `slow_tick` pulse. Codes 5 to 7 produce no tick and the counter holds.
- R4: A cycle with `presc_clr` high restarts all dividers. With `start` raised in the next cycle and a cycle-based source of division D, the first underflow appears exactly (reload+1)·D cycles after the clearing edge.
- R5: In event mode (bits [1:0] = 1) with bit 2 low, the counter steps on edges of the synchronised pin of the polarity given by bit 4 (0 rising, 1 falling). With bit 2 high it steps on `casc_in` pulses only, and the pin is ignored.
- R6: In measurement mode (bits [1:0] = 2) with bit 3 low, each edge of the bit-4 polarity captures the tick count since the previous such edge, including a tick in the edge cycle. After the capture, `rd_val` shows that value and `irq` pulses.
- R7: With bit 3 high, measurement mode captures on both edges, so captures alternate between high time and low time in ticks.
- R8: If the measurement count is at 65535 when a tick arrives, it wraps to 0, `ovf_flag` sets and `irq` pulses. The flag stays set until the next control write.
- R9: `irq` pulses for exactly one cycle per underflow, capture or overflow. In counting modes it coincides with `uf_out`.
- R10: While `start` is low the counter holds and pin edges have no effect. A reload write in that state also loads the counter, which `rd_val` shows in the counting modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 reload word, 1 control byte |
| wr_data | input | 16 | Write data (control uses bits [7:0]) |
| start | input | 1 | Run enable, level |
| presc_clr | input | 1 | Restart of the tick dividers |
| slow_tick | input | 1 | One-cycle pulses from the slow clock domain |
| ext_in | input | 1 | Asynchronous external signal |
| casc_in | input | 1 | Underflow pulse from another channel |
| rd_val | output | 16 | Capture register in measurement mode, counter otherwise |
| ovf_flag | output | 1 | Sticky measurement overflow |
| uf_out | output | 1 | One-cycle underflow pulse |
| irq | output | 1 | One-cycle interrupt request |

## Verification
The bench measures the first underflow after a divider restart, and a design that ignored `presc_clr` or counted one tick too many would be off by whole divider periods. It ends period measurements on an unpaired rising edge, so a design that captured on the wrong polarity would report one interrupt too many or too few. Width captures must alternate between 10 and 30, which catches a design that cleared the count to 0 instead of counting the coinciding tick. A run of 65536 ticks without edges must set the flag on the exact cycle and keep it until a control write. A stopped timer that still reacted to pin edges, or a cascade mode that still listened to the pin, would show up as extra interrupts or a changed count.

// File: rtl/mtmr_pkg.sv
package mtmr_pkg;
   typedef enum logic [1:0] {
      MD_TIMER = 2'd0,
      MD_EVENT = 2'd1,
      MD_MEAS  = 2'd2,
      MD_SPARE = 2'd3
   } mode_e;

   // control byte: src[7:5] fall[4] width[3] casc[2] mode[1:0]
   typedef struct packed {
      logic [2:0] src;
      logic       fall;
      logic       width;
      logic       casc;
      mode_e      mode;
   } ctrl_t;
endpackage

// File: rtl/mtmr_presc.sv
module mtmr_presc #(
   parameter int DIV_A    = 8,
   parameter int DIV_B    = 32,
   parameter int DIV_C    = 64,
   parameter int SLOW_DIV = 32
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clr,
   input  logic       slow_tick,
   input  logic [2:0] sel,
   output logic       tick
);
   localparam int PW = $clog2(DIV_C);
   localparam int SW = $clog2(SLOW_DIV);
   localparam logic [PW-1:0] MA = PW'(DIV_A - 1);
   localparam logic [PW-1:0] MB = PW'(DIV_B - 1);
   localparam logic [PW-1:0] MC = PW'(DIV_C - 1);
   localparam logic [SW-1:0] MS = SW'(SLOW_DIV - 1);

   initial begin
      assert (DIV_A >= 2 && (DIV_A & (DIV_A - 1)) == 0) else $error("DIV_A must be a power of two");
      assert (DIV_B > DIV_A && (DIV_B & (DIV_B - 1)) == 0) else $error("DIV_B must be a larger power of two");
      assert (DIV_C > DIV_B && (DIV_C & (DIV_C - 1)) == 0) else $error("DIV_C must be a larger power of two");
      assert (SLOW_DIV >= 2 && (SLOW_DIV & (SLOW_DIV - 1)) == 0) else $error("SLOW_DIV must be a power of two");
   end

   logic [PW-1:0] pcnt;
   logic [SW-1:0] scnt;
   logic tick_a, tick_b, tick_c, tick_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    pcnt <= '0;
      else if (clr)  pcnt <= '0;
      else           pcnt <= pcnt + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          scnt <= '0;
      else if (clr)        scnt <= '0;
      else if (slow_tick)  scnt <= scnt + 1'b1;
   end

   assign tick_a = (pcnt & MA) == MA;
   assign tick_b = (pcnt & MB) == MB;
   assign tick_c = pcnt == MC;
   assign tick_s = slow_tick && (scnt == MS);

   always_comb begin
      case (sel)
         3'd0:    tick = 1'b1;
         3'd1:    tick = tick_a;
         3'd2:    tick = tick_b;
         3'd3:    tick = tick_c;
         3'd4:    tick = tick_s;
         default: tick = 1'b0;
      endcase
   end

   // R4: a restart leaves the dividers far from their next tick
   a_r4_clr_restart: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> !tick_a);
endmodule

// File: rtl/mtmr_sync.sv
module mtmr_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic rise,
   output logic fall
);
   initial begin
      assert (STAGES >= 2) else $error("at least two synchroniser stages are needed");
   end

   logic [STAGES:0] sh;

   for (genvar i = 0; i <= STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh[0] <= 1'b0;
            else        sh[0] <= din;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh[i] <= 1'b0;
            else        sh[i] <= sh[i-1];
         end
      end
   end

   assign rise = sh[STAGES-1] & ~sh[STAGES];
   assign fall = ~sh[STAGES-1] & sh[STAGES];

   // R5: a rising event is followed by a high level one stage later
   a_r5_rise_level: assert property (@(posedge clk) disable iff (!rst_n)
      rise |=> sh[STAGES]);
endmodule

// File: rtl/mtmr_core.sv
module mtmr_core
   import mtmr_pkg::*;
#(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         run,
   input  ctrl_t        ctrl,
   input  logic [W-1:0] reload,
   input  logic         tick_int,
   input  logic         e_rise,
   input  logic         e_fall,
   input  logic         casc_in,
   input  logic         ld_en,
   input  logic [W-1:0] ld_val,
   input  logic         ctrl_wr,
   output logic [W-1:0] cnt,
   output logic [W-1:0] cap,
   output logic         ovf,
   output logic         uf,
   output logic         irq
);
   localparam logic [W-1:0] CMAX = '1;

   initial begin
      assert (W >= 2) else $error("counter width too small");
   end

   logic act_edge, meas_evt, step;

   assign act_edge = ctrl.fall ? e_fall : e_rise;
   assign meas_evt = ctrl.width ? (e_rise | e_fall) : act_edge;
   assign step     = (ctrl.mode == MD_EVENT) ? (ctrl.casc ? casc_in : act_edge) : tick_int;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         cap <= '0;
         ovf <= 1'b0;
         uf  <= 1'b0;
         irq <= 1'b0;
      end else begin
         uf  <= 1'b0;
         irq <= 1'b0;
         if (ctrl_wr) ovf <= 1'b0;
         if (!run) begin
            if (ld_en) cnt <= ld_val;
         end else if (ctrl.mode == MD_MEAS) begin
            if (meas_evt) begin
               cap <= cnt;
               cnt <= {{(W-1){1'b0}}, tick_int};
               irq <= 1'b1;
            end else if (tick_int) begin
               if (cnt == CMAX) begin
                  cnt <= '0;
                  ovf <= 1'b1;
                  irq <= 1'b1;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
         end else if (step) begin
            if (cnt == '0) begin
               cnt <= reload;
               uf  <= 1'b1;
               irq <= 1'b1;
            end else begin
               cnt <= cnt - 1'b1;
            end
         end
      end
   end

   // R10: stopped counter keeps its value unless loaded
   a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !ld_en) |=> $stable(cnt));
   // R8: overflow flag is sticky until a control write
   a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf && !ctrl_wr) |=> ovf);
   // R6: a measurement interrupt leaves the count restarted
   a_r6_restart: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && ctrl.mode == MD_MEAS && $past(ctrl.mode) == MD_MEAS) |-> (cnt <= 1));
   // R9: every underflow also requests an interrupt
   a_r9_uf_irq: assert property (@(posedge clk) disable iff (!rst_n)
      uf |-> irq);
endmodule

// File: rtl/mtmr_top.sv
module mtmr_top
   import mtmr_pkg::*;
#(
   parameter int W           = 16,
   parameter int DIV_A       = 8,
   parameter int DIV_B       = 32,
   parameter int DIV_C       = 64,
   parameter int SLOW_DIV    = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_en,
   input  logic         wr_sel,
   input  logic [W-1:0] wr_data,
   input  logic         start,
   input  logic         presc_clr,
   input  logic         slow_tick,
   input  logic         ext_in,
   input  logic         casc_in,
   output logic [W-1:0] rd_val,
   output logic         ovf_flag,
   output logic         uf_out,
   output logic         irq
);
   localparam int CW = $bits(ctrl_t);

   initial begin
      assert (W >= CW) else $error("write port narrower than control byte");
   end

   ctrl_t        ctrl_q;
   logic [W-1:0] reload_q;
   logic         ctrl_wr, rel_wr, ld_en;
   logic         tick_int, e_rise, e_fall;
   logic [W-1:0] cnt, cap;

   assign ctrl_wr = wr_en & wr_sel;
   assign rel_wr  = wr_en & ~wr_sel;
   assign ld_en   = rel_wr & ~start;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q   <= '0;
         reload_q <= '0;
      end else begin
         if (ctrl_wr) ctrl_q   <= ctrl_t'(wr_data[CW-1:0]);
         if (rel_wr)  reload_q <= wr_data;
      end
   end

   mtmr_presc #(.DIV_A(DIV_A), .DIV_B(DIV_B), .DIV_C(DIV_C), .SLOW_DIV(SLOW_DIV)) u_presc (
      .clk(clk), .rst_n(rst_n), .clr(presc_clr), .slow_tick(slow_tick),
      .sel(ctrl_q.src), .tick(tick_int)
   );

   mtmr_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .din(ext_in), .rise(e_rise), .fall(e_fall)
   );

   mtmr_core #(.W(W)) u_core (
      .clk(clk), .rst_n(rst_n), .run(start), .ctrl(ctrl_q), .reload(reload_q),
      .tick_int(tick_int), .e_rise(e_rise), .e_fall(e_fall), .casc_in(casc_in),
      .ld_en(ld_en), .ld_val(wr_data), .ctrl_wr(ctrl_wr),
      .cnt(cnt), .cap(cap), .ovf(ovf_flag), .uf(uf_out), .irq(irq)
   );

   assign rd_val = (ctrl_q.mode == MD_MEAS) ? cap : cnt;

   // R1: after reset nothing is pending
   a_r1_quiet: assert property (@(posedge clk) $rose(rst_n) |-> (!irq && !uf_out && !ovf_flag));
endmodule

// File: tb/sim_mtmr_top.sv
module sim_mtmr_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0, wr_sel = 1'b0;
   logic [15:0] wr_data = '0;
   logic        start = 1'b0, presc_clr = 1'b0, slow_tick = 1'b0;
   logic        ext_in = 1'b0, casc_in = 1'b0;
   logic [15:0] rd_val;
   logic        ovf_flag, uf_out, irq;

   int checks = 0, fails = 0;
   int irq_cnt = 0, uf_cnt = 0, mism = 0;
   int last_cap = 0, prev_cap = 0;
   int sdiv = 0;
   bit tm_chk = 1'b0;
   bit done = 1'b0;

   // {src[3], reload[16], period[20], check_first[1]}
   localparam logic [39:0] VEC [5] = '{
      {3'd0, 16'd9, 20'd10,  1'b1},
      {3'd1, 16'd3, 20'd32,  1'b1},
      {3'd2, 16'd1, 20'd64,  1'b1},
      {3'd3, 16'd0, 20'd64,  1'b1},
      {3'd4, 16'd1, 20'd192, 1'b0}
   };

   always #4 clk = ~clk;

   mtmr_top u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .start(start), .presc_clr(presc_clr), .slow_tick(slow_tick), .ext_in(ext_in),
      .casc_in(casc_in), .rd_val(rd_val), .ovf_flag(ovf_flag), .uf_out(uf_out), .irq(irq)
   );

   always @(negedge clk) begin
      sdiv = (sdiv == 2) ? 0 : sdiv + 1;
      slow_tick <= (sdiv == 0);
   end

   always @(negedge clk) begin
      if (rst_n) begin
         if (irq) begin
            irq_cnt++;
            prev_cap = last_cap;
            last_cap = rd_val;
         end
         if (uf_out) uf_cnt++;
         if (tm_chk && (uf_out != irq)) mism++;
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wr(input bit sel, input logic [15:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = sel; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   function automatic logic [15:0] cw(input int src, input bit fall, input bit width,
                                      input bit casc, input int mode);
      return 16'((src << 5) | (fall << 4) | (width << 3) | (casc << 2) | mode);
   endfunction

   task automatic pin(input bit v, input int n);
      ext_in = v;
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      int n, d, u;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(rd_val == 0 && !irq && !uf_out && !ovf_flag, "R1", int'(rd_val), 0);

      // R10 load while stopped, then hold
      wr(1, cw(0, 0, 0, 0, 0));
      wr(0, 16'h1234);
      check(rd_val == 16'h1234, "R10 load", int'(rd_val), 'h1234);
      repeat (30) @(negedge clk);
      check(rd_val == 16'h1234, "R10 hold", int'(rd_val), 'h1234);

      // R3 unused source code gives no ticks
      wr(1, cw(5, 0, 0, 0, 0));
      u = uf_cnt;
      start = 1'b1;
      repeat (100) @(negedge clk);
      check(rd_val == 16'h1234 && uf_cnt == u, "R3 no tick", int'(rd_val), 'h1234);
      start = 1'b0;

      // R2 R3 R4 table of sources and reloads
      tm_chk = 1'b1;
      for (int i = 0; i < 5; i++) begin
         logic [39:0] v;
         v = VEC[i];
         start = 1'b0;
         wr(1, cw(int'(v[39:37]), 0, 0, 0, 0));
         wr(0, v[36:21]);
         @(negedge clk);
         presc_clr = 1'b1;
         @(negedge clk);
         presc_clr = 1'b0;
         start = 1'b1;
         n = 0;
         do begin @(negedge clk); n++; end while (!uf_out && n < 2000);
         if (v[0]) check(n == int'(v[20:1]), "R4 first underflow", n, int'(v[20:1]));
         n = 0;
         do begin @(negedge clk); n++; end while (!uf_out && n < 2000);
         check(n == int'(v[20:1]), "R2 R3 underflow period", n, int'(v[20:1]));
         check(rd_val == v[36:21], "R2 reload after underflow", int'(rd_val), int'(v[36:21]));
      end
      start = 1'b0;
      tm_chk = 1'b0;
      check(mism == 0, "R9 irq with uf", mism, 0);

      // R5 external rising edges
      wr(1, cw(0, 0, 0, 0, 1));
      wr(0, 16'd2);
      start = 1'b1;
      u = uf_cnt;
      for (int k = 0; k < 2; k++) begin pin(1, 5); pin(0, 5); end
      check(rd_val == 0 && uf_cnt == u, "R5 ext count", int'(rd_val), 0);
      pin(1, 5); pin(0, 5);
      check(rd_val == 2 && uf_cnt == u + 1, "R5 ext underflow", uf_cnt - u, 1);

      // R5 cascade source ignores the pin
      start = 1'b0;
      wr(1, cw(0, 0, 0, 1, 1));
      wr(0, 16'd1);
      start = 1'b1;
      u = uf_cnt;
      for (int k = 0; k < 3; k++) begin pin(1, 5); pin(0, 5); end
      check(rd_val == 1 && uf_cnt == u, "R5 casc pin ignored", int'(rd_val), 1);
      for (int k = 0; k < 2; k++) begin
         casc_in = 1'b1; @(negedge clk); casc_in = 1'b0; repeat (3) @(negedge clk);
      end
      check(rd_val == 1 && uf_cnt == u + 1, "R5 casc underflow", uf_cnt - u, 1);

      // R6 period, rising polarity, trailing unpaired rise
      start = 1'b0;
      wr(1, cw(0, 0, 0, 0, 2));
      start = 1'b1;
      d = irq_cnt;
      for (int k = 0; k < 3; k++) begin pin(1, 10); pin(0, 30); end
      pin(1, 10);
      check(last_cap == 40 && prev_cap == 40, "R6 rising period", last_cap, 40);
      check(irq_cnt - d == 4, "R6 rising count", irq_cnt - d, 4);

      // R6 period, falling polarity
      start = 1'b0;
      pin(0, 5);
      wr(1, cw(0, 1, 0, 0, 2));
      start = 1'b1;
      d = irq_cnt;
      for (int k = 0; k < 3; k++) begin pin(1, 15); pin(0, 25); end
      pin(1, 10);
      check(last_cap == 40 && prev_cap == 40, "R6 falling period", last_cap, 40);
      check(irq_cnt - d == 3, "R6 falling count", irq_cnt - d, 3);

      // R7 width, both edges
      start = 1'b0;
      pin(0, 5);
      wr(1, cw(0, 0, 1, 0, 2));
      start = 1'b1;
      d = irq_cnt;
      for (int k = 0; k < 3; k++) begin pin(1, 10); pin(0, 30); end
      check(last_cap == 10 && prev_cap == 30, "R7 width captures", last_cap, 10);
      check(irq_cnt - d == 6, "R7 width count", irq_cnt - d, 6);

      // R10 stopped measurement ignores edges
      start = 1'b0;
      d = irq_cnt;
      for (int k = 0; k < 2; k++) begin pin(1, 6); pin(0, 6); end
      check(irq_cnt == d && last_cap == 10, "R10 stopped edges", irq_cnt - d, 0);

      // R8 overflow
      wr(1, cw(0, 0, 0, 0, 2));
      wr(0, 16'd0);
      d = irq_cnt;
      start = 1'b1;
      n = 0;
      do begin @(negedge clk); n++; end while (!ovf_flag && n < 70000);
      check(n == 65536, "R8 overflow cycle", n, 65536);
      repeat (200) @(negedge clk);
      check(ovf_flag == 1'b1 && irq_cnt - d == 1, "R8 sticky", irq_cnt - d, 1);
      start = 1'b0;
      wr(1, cw(0, 0, 0, 0, 2));
      check(ovf_flag == 1'b0, "R8 cleared", int'(ovf_flag), 0);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule